// File: doc/BRIEF.md
# Prescaled Event Timer with Slot-Gated One-Shot Control

This block is an up-counting timer whose counting rate comes from a clock prescaler. It raises three events: a match on compare channel A, a match on compare channel B, and a natural wrap (update) when the count passes its top value. Each event sets a sticky status flag. When the event's request enable is on, the event also sets a separate request latch that drives a request line to an external transfer engine. The latch stays set until that engine acknowledges it.

A second counter, the slot counter, advances on every natural wrap of the timer. In one-shot mode it switches itself off when it reaches its own top value. In gated mode the timer counts only while the slot counter is enabled. Software can therefore emit a fixed number of timer periods and have the timer freeze after the last wrap.

The divider written by software goes into a holding register first. It becomes the active divider only at a natural wrap or at a software-forced update. A counter started right after a new divider is written therefore runs its first period at the old rate. Issuing a forced update before starting makes the first period use the new divider. The run bit only gates the counting clock: flags, requests and all other state keep their values while it is off.

Top module: `pulse_slot_timer`

## Requirements
- R1: After reset, the count, slot count, status flags, request lines and slot enable are all 0, and the active divider is 0 (undivided).
- R2: While running with active divider D, the count advances by one every D+1 clock cycles. Above the top value (register address 2) the count wraps to 0, and this wrap sets the update flag (flag bit 2).
- R3: A value written to the divider register (address 1) is only held. The active divider takes it at the next natural wrap or forced update, so the period before that transfer runs at the old divider.
- R4: Writing 1 to bit 0 of the force register (address 6) clears the count and the prescaler and loads the held divider in the same cycle. It sets the update flag and update request unless the quiet bit (control bit 1, address 0) is 1.
- R5: When the count becomes equal to compare A (address 3) or compare B (address 4), flag bit 0 or flag bit 1 is set, respectively.
- R6: With the run bit (control bit 0) at 0, the count holds its value and flags and requests keep their state. A forced update still works while stopped.
- R7: An event whose request-enable bit is on (address 5: bit 0 = A, bit 1 = B, bit 2 = update) sets req_o at the same bit position. Repeated events before acknowledge leave a single pending request. One cycle of ack_i at that bit clears it, and the flag is not affected.
- R8: An event whose request-enable bit is off sets its flag but never its request line.
- R9: The slot counter advances on each natural wrap while enabled (address 9: bit 0 enable, bit 1 one-shot; writing this register also clears the slot count). In one-shot mode, a wrap that finds the slot count equal to the slot top (address 8) returns it to 0 and clears the slot enable.
- R10: With the gated bit (control bit 2) at 1, the timer counts only while the slot enable is 1. After the final one-shot wrap, the count stays at 0.
- R11: Writing 1s to the flag-clear register (address 7) clears the corresponding flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| ack_i | input | 3 | Request acknowledge per event (bit 0 A, bit 1 B, bit 2 update) |
| cnt_o | output | 16 | Current timer count |
| slot_o | output | 8 | Current slot count |
| slot_en_o | output | 1 | Slot counter enable |
| flag_o | output | 3 | Status flags (bit 0 A, bit 1 B, bit 2 update) |
| req_o | output | 3 | Pending transfer requests, same bit order |

## Verification
The hardest case to reach is the first period after a new divider is written. The holding register and the active divider differ at that point, but only the counting rate shows the difference. The stimulus writes a divider of 3 while the active divider is still 0 after reset, starts the timer, and checks the count on every cycle. The first ten steps must arrive one per clock and the later steps one per four clocks. A second run writes a new divider, forces an update, and checks that the new rate applies from the first step. The one-shot gated run is checked cycle by cycle across the final wrap, to catch a timer that runs one step past the point where the slot counter disables itself.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [3:0] {
    A_CTRL     = 4'd0,
    A_DIV      = 4'd1,
    A_TOP      = 4'd2,
    A_CMPA     = 4'd3,
    A_CMPB     = 4'd4,
    A_REQEN    = 4'd5,
    A_FORCE    = 4'd6,
    A_FLAGCLR  = 4'd7,
    A_SLOTTOP  = 4'd8,
    A_SLOTCTRL = 4'd9
  } reg_addr_e;

  localparam int EV_A   = 0;
  localparam int EV_B   = 1;
  localparam int EV_UPD = 2;
  localparam int NUM_EV = 3;

  localparam int CTL_RUN   = 0;
  localparam int CTL_QUIET = 1;
  localparam int CTL_GATED = 2;
  localparam int CTL_W     = 3;
endpackage

// File: rtl/pst_timebase.sv
module pst_timebase #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             force_i,
  input  logic [DIV_W-1:0] div_pre_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             hit_a_o,
  output logic             hit_b_o
);
  logic [DIV_W-1:0] psc_q, psc_d, div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick, wrap;
  logic             psc_en, cnt_en, div_en;

  always_comb begin
    tick   = run_i && !force_i && (psc_q >= div_q);
    wrap   = tick && (cnt_q >= top_i);
    psc_d  = psc_q;
    cnt_d  = cnt_q;
    div_d  = div_q;
    psc_en = 1'b0;
    cnt_en = 1'b0;
    div_en = 1'b0;
    if (force_i) begin
      psc_d  = '0;
      cnt_d  = '0;
      div_d  = div_pre_i;
      psc_en = 1'b1;
      cnt_en = 1'b1;
      div_en = 1'b1;
    end else if (run_i) begin
      psc_en = 1'b1;
      psc_d  = tick ? '0 : psc_q + 1'b1;
      if (tick) begin
        cnt_en = 1'b1;
        cnt_d  = wrap ? '0 : cnt_q + 1'b1;
      end
      if (wrap) begin
        div_en = 1'b1;
        div_d  = div_pre_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      if (psc_en) psc_q <= psc_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (div_en) div_q <= div_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign wrap_o  = wrap;
  assign hit_a_o = tick && (cnt_d == cmp_a_i);
  assign hit_b_o = tick && (cnt_d == cmp_b_i);

  p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_i || wrap) |=> $stable(div_q));
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !force_i) |=> $stable(cnt_q));
  p_force_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> (cnt_q == '0 && psc_q == '0));
endmodule

// File: rtl/pst_evt_latch.sv
module pst_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic req_en_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic flag_o,
  output logic req_o
);
  logic flag_q, flag_d, req_q, req_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    req_d = req_q;
    if (set_i && req_en_i) req_d = 1'b1;
    else if (ack_i)        req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      req_q  <= req_d;
    end
  end

  assign flag_o = flag_q;
  assign req_o  = req_q;

  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !req_q);
  p_no_req_wo_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && !(set_i && req_en_i)) |=> !req_q);
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/pst_slot_ctr.sv
module pst_slot_ctr #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic              cfg_en_i,
  input  logic              cfg_one_shot_i,
  input  logic [SLOT_W-1:0] top_i,
  input  logic              step_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              en_o
);
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              en_q, en_d, os_q, os_d;
  logic              last;

  always_comb begin
    last   = step_i && en_q && (slot_q >= top_i);
    slot_d = slot_q;
    en_d   = en_q;
    os_d   = os_q;
    if (cfg_wr_i) begin
      slot_d = '0;
      en_d   = cfg_en_i;
      os_d   = cfg_one_shot_i;
    end else if (step_i && en_q) begin
      slot_d = last ? '0 : slot_q + 1'b1;
      if (last && os_q) en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      en_q   <= 1'b0;
      os_q   <= 1'b0;
    end else begin
      slot_q <= slot_d;
      en_q   <= en_d;
      os_q   <= os_d;
    end
  end

  assign slot_o = slot_q;
  assign en_o   = en_q;

  p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_i && os_q && en_q && step_i && slot_q == top_i) |=> (!en_q && slot_q == '0));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_i && !(step_i && en_q)) |=> $stable(slot_q));
endmodule

// File: rtl/pulse_slot_timer.sv
module pulse_slot_timer
  import pst_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int SLOT_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NUM_EV-1:0] ack_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              slot_en_o,
  output logic [NUM_EV-1:0] flag_o,
  output logic [NUM_EV-1:0] req_o
);
  logic [CTL_W-1:0]  ctrl_q;
  logic [DIV_W-1:0]  div_pre_q;
  logic [CNT_W-1:0]  top_q, cmp_a_q, cmp_b_q;
  logic [NUM_EV-1:0] req_en_q;
  logic [SLOT_W-1:0] slot_top_q;

  logic              sel_ctrl, sel_div, sel_top, sel_cmpa, sel_cmpb;
  logic              sel_reqen, sel_slottop, sel_slotctrl;
  logic              force_upd, run_eff, wrap, hit_a, hit_b, slot_en;
  logic [NUM_EV-1:0] ev_set, flag_clr;

  always_comb begin
    sel_ctrl     = wr_en && (wr_addr == A_CTRL);
    sel_div      = wr_en && (wr_addr == A_DIV);
    sel_top      = wr_en && (wr_addr == A_TOP);
    sel_cmpa     = wr_en && (wr_addr == A_CMPA);
    sel_cmpb     = wr_en && (wr_addr == A_CMPB);
    sel_reqen    = wr_en && (wr_addr == A_REQEN);
    sel_slottop  = wr_en && (wr_addr == A_SLOTTOP);
    sel_slotctrl = wr_en && (wr_addr == A_SLOTCTRL);
    force_upd    = wr_en && (wr_addr == A_FORCE) && wr_data[0];
    flag_clr     = (wr_en && (wr_addr == A_FLAGCLR)) ? wr_data[NUM_EV-1:0] : '0;
    run_eff      = ctrl_q[CTL_RUN] && (!ctrl_q[CTL_GATED] || slot_en);
    ev_set[EV_A]   = hit_a;
    ev_set[EV_B]   = hit_b;
    ev_set[EV_UPD] = wrap || (force_upd && !ctrl_q[CTL_QUIET]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      div_pre_q  <= '0;
      top_q      <= '0;
      cmp_a_q    <= '0;
      cmp_b_q    <= '0;
      req_en_q   <= '0;
      slot_top_q <= '0;
    end else begin
      if (sel_ctrl)    ctrl_q     <= wr_data[CTL_W-1:0];
      if (sel_div)     div_pre_q  <= wr_data[DIV_W-1:0];
      if (sel_top)     top_q      <= wr_data[CNT_W-1:0];
      if (sel_cmpa)    cmp_a_q    <= wr_data[CNT_W-1:0];
      if (sel_cmpb)    cmp_b_q    <= wr_data[CNT_W-1:0];
      if (sel_reqen)   req_en_q   <= wr_data[NUM_EV-1:0];
      if (sel_slottop) slot_top_q <= wr_data[SLOT_W-1:0];
    end
  end

  pst_timebase #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_eff),
    .force_i   (force_upd),
    .div_pre_i (div_pre_q),
    .top_i     (top_q),
    .cmp_a_i   (cmp_a_q),
    .cmp_b_i   (cmp_b_q),
    .cnt_o     (cnt_o),
    .wrap_o    (wrap),
    .hit_a_o   (hit_a),
    .hit_b_o   (hit_b)
  );

  for (genvar e = 0; e < NUM_EV; e++) begin : g_evt
    pst_evt_latch u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (ev_set[e]),
      .req_en_i (req_en_q[e]),
      .clr_i    (flag_clr[e]),
      .ack_i    (ack_i[e]),
      .flag_o   (flag_o[e]),
      .req_o    (req_o[e])
    );
  end

  pst_slot_ctr #(.SLOT_W(SLOT_W)) u_slot (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr_i       (sel_slotctrl),
    .cfg_en_i       (wr_data[0]),
    .cfg_one_shot_i (wr_data[1]),
    .top_i          (slot_top_q),
    .step_i         (wrap),
    .slot_o         (slot_o),
    .en_o           (slot_en)
  );

  assign slot_en_o = slot_en;

  p_gate_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTL_GATED] && !slot_en && !force_upd) |=> $stable(cnt_o));
  p_quiet_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (force_upd && ctrl_q[CTL_QUIET] && !flag_o[EV_UPD] && !flag_clr[EV_UPD]) |=> !flag_o[EV_UPD]);
endmodule

// File: tb/sim_pulse_slot_timer.sv
module sim_pulse_slot_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  ack_i;
  logic [15:0] cnt_o;
  logic [7:0]  slot_o;
  logic        slot_en_o;
  logic [2:0]  flag_o;
  logic [2:0]  req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] exp;
  } item_t;
  item_t sb[$];

  localparam int S_CNT = 0, S_FLAG = 1, S_REQ = 2, S_SLOT = 3, S_SEN = 4;

  always #5 clk = ~clk;

  pulse_slot_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack_i(ack_i), .cnt_o(cnt_o), .slot_o(slot_o), .slot_en_o(slot_en_o),
    .flag_o(flag_o), .req_o(req_o)
  );

  function automatic logic [31:0] observe(input int sel);
    case (sel)
      S_CNT:   return 32'(cnt_o);
      S_FLAG:  return 32'(flag_o);
      S_REQ:   return 32'(req_o);
      S_SLOT:  return 32'(slot_o);
      default: return 32'(slot_en_o);
    endcase
  endfunction

  // monitor: pops every expectation queued since the last falling edge
  always @(negedge clk) begin
    item_t it;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      checks++;
      if (observe(it.sel) !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.tag, it.sel,
                 observe(it.sel), it.exp);
      end
    end
  end

  task automatic expect_now(input int sel, input logic [31:0] v, input string tag);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = v;
    sb.push_back(it);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic ack(input logic [2:0] m);
    ack_i = m;
    step(1);
    ack_i = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; ack_i = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    expect_now(S_CNT, 0, "R1"); expect_now(S_FLAG, 0, "R1"); expect_now(S_REQ, 0, "R1");
    expect_now(S_SLOT, 0, "R1"); expect_now(S_SEN, 0, "R1");

    // R3: divider written but active still 0, first period undivided
    wr(4'd2, 16'd9); wr(4'd3, 16'd2); wr(4'd4, 16'd7); wr(4'd5, 16'b001); wr(4'd1, 16'd3);
    wr(4'd0, 16'b001);
    expect_now(S_CNT, 0, "R3");
    for (int n = 1; n <= 18; n++) begin
      step(1);
      if (n <= 10) expect_now(S_CNT, n % 10, "R3 old divider");
      else         expect_now(S_CNT, (n - 10) / 4, "R2 divided rate");
    end
    expect_now(S_FLAG, 3'b111, "R5 R2 flags");
    expect_now(S_REQ, 3'b001, "R8 only enabled request");

    // R6: stopping only gates counting
    wr(4'd0, 16'b000);
    expect_now(S_CNT, 2, "R6 stop point");
    step(1);
    held = cnt_o;
    step(6);
    expect_now(S_CNT, 32'(held), "R6 count held");
    expect_now(S_FLAG, 3'b111, "R6 flags held");
    expect_now(S_REQ, 3'b001, "R6 request held");

    // R7: two A events, one pending request, one ack clears it
    ack(3'b001);
    expect_now(S_REQ, 0, "R7 ack clears");
    expect_now(S_FLAG, 3'b111, "R7 flag untouched");
    wr(4'd7, 16'b111);
    expect_now(S_FLAG, 0, "R11 clear");

    // R4: forced update while stopped
    wr(4'd5, 16'b100);
    wr(4'd6, 16'd1);
    expect_now(S_CNT, 0, "R4 force clears");
    expect_now(S_FLAG, 3'b100, "R4 update flag");
    expect_now(S_REQ, 3'b100, "R7 update request");
    ack(3'b100);
    wr(4'd7, 16'b111);
    wr(4'd0, 16'b010);
    wr(4'd1, 16'd1);
    wr(4'd6, 16'd1);
    expect_now(S_FLAG, 0, "R4 quiet flag");
    expect_now(S_REQ, 0, "R4 quiet request");
    wr(4'd0, 16'b011);
    for (int n = 1; n <= 4; n++) begin
      step(1);
      expect_now(S_CNT, n / 2, "R3 force loads divider");
    end
    wr(4'd0, 16'b000);

    // R9 R10: gated, one-shot, two slots
    wr(4'd1, 16'd0); wr(4'd2, 16'd2); wr(4'd6, 16'd1);
    expect_now(S_CNT, 0, "R4 force");
    wr(4'd8, 16'd1);
    wr(4'd0, 16'b101);
    step(4);
    expect_now(S_CNT, 0, "R10 gated off");
    wr(4'd9, 16'b011);
    expect_now(S_SEN, 1, "R9 enable");
    for (int n = 1; n <= 6; n++) begin
      step(1);
      expect_now(S_CNT, n % 3, "R10 gated count");
      expect_now(S_SLOT, (n >= 3 && n < 6) ? 1 : 0, "R9 slot");
      expect_now(S_SEN, (n < 6) ? 1 : 0, "R9 one-shot stop");
    end
    step(4);
    expect_now(S_CNT, 0, "R10 frozen after last wrap");
    expect_now(S_SEN, 0, "R9 stays off");
    step(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule